// File: doc/BRIEF.md
# Bidirectional Routing Repeater Bank

This block is a bank of programmable repeaters placed where two routing segments meet. Each repeater lane joins side A (left or top) to side B (right or bottom). Each side carries one sector wire and one global wire, so a lane has four connections. Every connection has its own 3-bit one-hot source code. The code says whether the repeater drives that wire and, if it does, which of the lane's other wires supplies the value. The block senses the four wire values of each lane. For each connection it produces a drive value and a drive-enable, which the surrounding fabric uses to control the real wire driver.

Software loads the codes through a byte-wide write port. The port index picks a lane and a side. One byte holds both codes for that side: the global-wire code and the sector-wire code. The enables and values are purely combinational functions of the stored codes and the sensed wires. A code with more than one bit set is refused and raises a per-lane code error. Two connections that would each take their value from the other are both switched off and raise a per-lane loop error.

Top module: `repeater_bank`

## Requirements
- R1: After reset every stored code is 000, and all `drive_en`, `drive_val`, `code_err` and `loop_err` bits are low.
- R2: A write with `wr_en` high is stored at the next rising clock edge. `wr_idx[0]` selects the side (0 = A, 1 = B) and `wr_idx[IDX_W-1:1]` selects the lane. `wr_data[5:3]` is the global-wire code and `wr_data[2:0]` is the sector-wire code. `wr_data[7:6]` has no effect.
- R3: A write whose index is 2*NUM_LINES or higher changes no stored code, so no output changes.
- R4: A connection with code 000 has its drive-enable low.
- R5: Code 100 drives the connection from the global wire on the opposite side.
- R6: Code 010 drives the connection from the sector wire on the opposite side.
- R7: Code 001 drives the connection from the other wire on the same side (sector from global, global from sector).
- R8: A code with two or more bits set leaves that connection undriven and raises `code_err` for its lane.
- R9: When two enabled connections of a lane each select the other as source, both drive-enables are low and `loop_err` for that lane is high.
- R10: `drive_val` is low on every connection whose drive-enable is low.
- R11: Drive values follow changes on `sense` in the same cycle, with no clock edge needed.
- R12: Lanes are independent: a lane whose codes are 000 keeps all of its outputs low whatever the other lanes hold.

Connection order inside lane L is bit 4L+0 = side A sector, 4L+1 = side A global, 4L+2 = side B sector, 4L+3 = side B global. This order applies to `sense`, `drive_val` and `drive_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the code registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Code write strobe |
| wr_idx | input | IDX_W | Lane and side selector for a write |
| wr_data | input | 8 | Global code [5:3] and sector code [2:0] |
| sense | input | NUM_LINES*4 | Sensed wire values |
| drive_val | output | NUM_LINES*4 | Value to drive on each connection |
| drive_en | output | NUM_LINES*4 | Driver enable for each connection |
| code_err | output | NUM_LINES | A lane holds a code with several bits set |
| loop_err | output | NUM_LINES | A lane holds a mutually driving pair |

## Verification
A wrong stored code shows at `drive_en` right after the clock edge that loads it, because nothing but combinational decode sits between the code registers and the ports. A wrong source selection shows as a `drive_val` bit that disagrees with the selected `sense` bit within the same cycle that the sense pattern is applied. For this reason, every one of the 4096 code combinations of one lane is checked against all 16 patterns of its own sensed wires. The other lanes are checked at the same time to confirm they stay quiet.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

    localparam int CONNS  = 4;   // connections per lane
    localparam int CODE_W = 3;   // one-hot source code width

    typedef logic [CODE_W-1:0] src_code_t;
    typedef logic [1:0]        conn_idx_t;

    // connection index = {side, kind}; side 0 = A, kind 0 = sector
    typedef enum logic [1:0] {
        CONN_A_SEC = 2'd0,
        CONN_A_GLB = 2'd1,
        CONN_B_SEC = 2'd2,
        CONN_B_GLB = 2'd3
    } conn_e;

    localparam src_code_t CODE_OFF     = 3'b000;
    localparam src_code_t CODE_OPP_GLB = 3'b100;
    localparam src_code_t CODE_OPP_SEC = 3'b010;
    localparam src_code_t CODE_SAME    = 3'b001;

endpackage

// File: rtl/rpt_cfg_regs.sv
module rpt_cfg_regs
    import rpt_pkg::*;
#(
    parameter int NUM_LINES = 5,
    parameter int IDX_W     = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [7:0]                        wr_data,
    output logic [NUM_LINES*CONNS*CODE_W-1:0] codes_flat
);

    localparam int SLOTS  = 2 * NUM_LINES;
    localparam int SLOT_W = 2 * CODE_W;

    logic unused_hi;
    assign unused_hi = ^wr_data[7:SLOT_W];

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            logic [SLOT_W-1:0] slot_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_q <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    slot_q <= wr_data[SLOT_W-1:0];
                end
            end

            // slot g = lane g/2, side g%2 -> connections 2*(g%2) (sector) and +1 (global)
            assign codes_flat[(2*g)*CODE_W   +: CODE_W] = slot_q[CODE_W-1:0];
            assign codes_flat[(2*g+1)*CODE_W +: CODE_W] = slot_q[SLOT_W-1:CODE_W];
        end
    endgenerate

endmodule

// File: rtl/rpt_src_decode.sv
module rpt_src_decode
    import rpt_pkg::*;
#(
    parameter int CONN = 0
) (
    input  src_code_t code,
    output logic      valid,
    output conn_idx_t src
);

    localparam logic SIDE = 1'((CONN >> 1) & 1);
    localparam logic KIND = 1'(CONN & 1);

    always_comb begin
        valid = 1'b1;
        src   = conn_idx_t'(CONN);
        unique case (code)
            CODE_OPP_GLB: src = {~SIDE, 1'b1};
            CODE_OPP_SEC: src = {~SIDE, 1'b0};
            CODE_SAME:    src = {SIDE, ~KIND};
            default:      valid = 1'b0;   // off or several bits set
        endcase
    end

endmodule

// File: rtl/rpt_lane.sv
module rpt_lane
    import rpt_pkg::*;
(
    input  logic [CONNS*CODE_W-1:0] codes,
    input  logic [CONNS-1:0]        sense,
    output logic [CONNS-1:0]        drv_en,
    output logic [CONNS-1:0]        drv_val,
    output logic                    code_err,
    output logic                    loop_err
);

    logic [CONNS-1:0] ok;
    logic [CONNS-1:0] mutual;
    conn_idx_t        src [CONNS];

    generate
        for (genvar c = 0; c < CONNS; c++) begin : g_dec
            rpt_src_decode #(.CONN(c)) u_dec (
                .code  (codes[c*CODE_W +: CODE_W]),
                .valid (ok[c]),
                .src   (src[c])
            );
        end
    endgenerate

    always_comb begin
        code_err = 1'b0;
        for (int c = 0; c < CONNS; c++) begin
            mutual[c]  = ok[c] && ok[src[c]] && (src[src[c]] == conn_idx_t'(c));
            drv_en[c]  = ok[c] && !mutual[c];
            drv_val[c] = drv_en[c] && sense[src[c]];
            code_err   = code_err || ((codes[c*CODE_W +: CODE_W] != CODE_OFF) && !ok[c]);
        end
        loop_err = |mutual;
    end

endmodule

// File: rtl/repeater_bank.sv
module repeater_bank
    import rpt_pkg::*;
#(
    parameter int NUM_LINES = 5,
    parameter int IDX_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [7:0]                 wr_data,
    input  logic [NUM_LINES*CONNS-1:0] sense,
    output logic [NUM_LINES*CONNS-1:0] drive_val,
    output logic [NUM_LINES*CONNS-1:0] drive_en,
    output logic [NUM_LINES-1:0]       code_err,
    output logic [NUM_LINES-1:0]       loop_err
);

    localparam int LANE_BITS = CONNS * CODE_W;

    logic [NUM_LINES*LANE_BITS-1:0] codes_flat;

    rpt_cfg_regs #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .codes_flat (codes_flat)
    );

    generate
        for (genvar l = 0; l < NUM_LINES; l++) begin : g_lane
            rpt_lane u_lane (
                .codes    (codes_flat[l*LANE_BITS +: LANE_BITS]),
                .sense    (sense[l*CONNS +: CONNS]),
                .drv_en   (drive_en[l*CONNS +: CONNS]),
                .drv_val  (drive_val[l*CONNS +: CONNS]),
                .code_err (code_err[l]),
                .loop_err (loop_err[l])
            );
        end
    endgenerate

endmodule

// File: rtl/rpt_checker.sv
module rpt_checker
    import rpt_pkg::*;
#(
    parameter int NUM_LINES = 5,
    parameter int IDX_W     = 4
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              wr_en,
    input logic [IDX_W-1:0]                  wr_idx,
    input logic [NUM_LINES*CONNS-1:0]        sense,
    input logic [NUM_LINES*CONNS-1:0]        drive_val,
    input logic [NUM_LINES*CONNS-1:0]        drive_en,
    input logic [NUM_LINES-1:0]              code_err,
    input logic [NUM_LINES-1:0]              loop_err,
    input logic [NUM_LINES*CONNS*CODE_W-1:0] codes_flat
);

    localparam logic [IDX_W:0] SLOTS = (IDX_W+1)'(2 * NUM_LINES);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (drive_en == '0 && code_err == '0 && loop_err == '0));

    assert_oob_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_idx} >= SLOTS)) |=> $stable(codes_flat));

    assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_val & ~drive_en) == '0);

    generate
        for (genvar l = 0; l < NUM_LINES; l++) begin : g_l
            assert_no_mutual_sec_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !(drive_en[4*l] && drive_en[4*l+2] &&
                  codes_flat[(4*l)*CODE_W +: CODE_W] == CODE_OPP_SEC &&
                  codes_flat[(4*l+2)*CODE_W +: CODE_W] == CODE_OPP_SEC));

            assert_no_mutual_sameside_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !(drive_en[4*l] && drive_en[4*l+1] &&
                  codes_flat[(4*l)*CODE_W +: CODE_W] == CODE_SAME &&
                  codes_flat[(4*l+1)*CODE_W +: CODE_W] == CODE_SAME));

            for (genvar c = 0; c < CONNS; c++) begin : g_c
                assert_off_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    (codes_flat[(4*l+c)*CODE_W +: CODE_W] == CODE_OFF) |-> !drive_en[4*l+c]);

                assert_same_side_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    (drive_en[4*l+c] && codes_flat[(4*l+c)*CODE_W +: CODE_W] == CODE_SAME)
                    |-> (drive_val[4*l+c] == sense[4*l+(c^1)]));

                assert_multibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
                    ($countones(codes_flat[(4*l+c)*CODE_W +: CODE_W]) > 1)
                    |-> (!drive_en[4*l+c] && code_err[l]));
            end
        end
    endgenerate

endmodule

bind repeater_bank rpt_checker #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .sense      (sense),
    .drive_val  (drive_val),
    .drive_en   (drive_en),
    .code_err   (code_err),
    .loop_err   (loop_err),
    .codes_flat (codes_flat)
);

// File: tb/tb_repeater_bank.sv
`timescale 1ns/1ps
module tb_repeater_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 5;
    localparam int IW         = 4;
    localparam int NC         = NL * 4;
    localparam int LANE       = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [7:0]    wr_data = '0;
    logic [NC-1:0] sense = '0;
    logic [NC-1:0] drive_val;
    logic [NC-1:0] drive_en;
    logic [NL-1:0] code_err;
    logic [NL-1:0] loop_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    repeater_bank #(.NUM_LINES(NL), .IDX_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .sense(sense), .drive_val(drive_val),
        .drive_en(drive_en), .code_err(code_err), .loop_err(loop_err)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic put(input logic [IW-1:0] idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check(input string tag, input logic [49:0] act, input logic [49:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected outputs of one lane from its 12 code bits and 4 sense bits
    task automatic model(input logic [11:0] codes, input logic [3:0] s,
                         output logic [3:0] en, output logic [3:0] val,
                         output logic cerr, output logic lerr);
        int       pt [4];
        logic [3:0] ok;
        cerr = 1'b0; lerr = 1'b0;
        for (int c = 0; c < 4; c++) begin
            logic [2:0] cd;
            cd = codes[c*3 +: 3];
            ok[c] = (cd == 3'b100) || (cd == 3'b010) || (cd == 3'b001);
            if (cd == 3'b100)      pt[c] = (c ^ 2) | 1;
            else if (cd == 3'b010) pt[c] = (c ^ 2) & 2;
            else                   pt[c] = c ^ 1;
            if ((cd[0] + cd[1] + cd[2]) > 1) cerr = 1'b1;
        end
        for (int c = 0; c < 4; c++) begin
            logic m;
            m = ok[c] && ok[pt[c]] && (pt[pt[c]] == c);
            if (m) lerr = 1'b1;
            en[c]  = ok[c] && !m;
            val[c] = en[c] && s[pt[c]];
        end
    endtask

    function automatic logic [49:0] pack_out();
        return {drive_en, drive_val, code_err, loop_err};
    endfunction

    initial begin
        logic [3:0] e, v;
        logic ce, le;
        logic [NC-1:0] xe, xv;
        logic [NL-1:0] xc, xl;

        repeat (3) @(negedge clk);
        sense = '1;
        #1;
        check("R1 reset outputs", pack_out(), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", pack_out(), '0);

        // exhaustive sweep of one lane: all code combinations, all sense patterns
        for (int combo = 0; combo < 4096; combo++) begin
            logic [11:0] cc;
            cc = 12'(combo);
            put(IW'(2*LANE),   {2'b00, cc[5:3],  cc[2:0]});
            put(IW'(2*LANE+1), {2'b00, cc[11:9], cc[8:6]});
            for (int s = 0; s < 16; s++) begin
                sense = '1;
                sense[4*LANE +: 4] = 4'(s);
                #1;   // no clock edge needed (R11)
                model(cc, 4'(s), e, v, ce, le);
                xe = '0; xv = '0; xc = '0; xl = '0;   // other lanes quiet (R12)
                xe[4*LANE +: 4] = e; xv[4*LANE +: 4] = v;
                xc[LANE] = ce; xl[LANE] = le;
                check("sweep R2 R4 R5 R6 R7 R8 R9 R10 R11 R12", pack_out(), {xe, xv, xc, xl});
            end
        end
        put(IW'(2*LANE), 8'h00);
        put(IW'(2*LANE+1), 8'h00);
        #1;
        check("R4 lane cleared", pack_out(), '0);

        // each lane in turn, upper data bits set and ignored (R2, R12)
        for (int l = 0; l < NL; l++) begin
            put(IW'(2*l), 8'b11_010_100);   // A glb <- B sec, A sec <- B glb
            sense = '0;
            sense[4*l+3] = 1'b1;            // B global high, B sector low
            #1;
            xe = '0; xv = '0;
            xe[4*l +: 4] = 4'b0011;
            xv[4*l +: 4] = 4'b0001;
            check("R2 R5 R6 R12 per-lane map", pack_out(), {xe, xv, 5'b0, 5'b0});
            put(IW'(2*l), 8'h00);
        end

        // out-of-range indices write nothing (R3)
        for (int i = 2*NL; i < 16; i++) put(IW'(i), 8'b00_001_001);
        sense = '1;
        #1;
        check("R3 out-of-range index", pack_out(), '0);

        // mutual pair across sides, then reset clears it (R9, R1)
        put(IW'(0), 8'b00_000_010);
        put(IW'(1), 8'b00_000_010);
        #1;
        check("R9 sector pair", pack_out(), {20'b0, 20'b0, 5'b0, 5'b00001});
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset", pack_out(), '0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule